// File: doc/BRIEF.md
# Port Parity Checker and Generator

This block handles parity for one data port of a buffered interface. The port bus is divided into byte lanes. Each lane holds eight data bits with a parity bit in its top position. Data arriving at the port is checked without being touched. A registered, active-low error flag reports whether any lane failed the check on the previous clock. Nothing downstream is required to act on that flag.

Data leaving the port goes through a generator. When generation is enabled, the generator rewrites the parity bit of every lane from that lane's data bits. When generation is disabled, the outgoing word passes through unchanged. One sense input sets odd or even parity, and the checker and the generator both follow it.

The lane count and the data bits per lane are parameters. The defaults give four lanes of nine bits, a 36-bit bus.

Top module: `ppg_port`

## Requirements
- R1: While `rst_n` is low, `perr_n` is 1. It stays 1 until the first rising clock edge at which `rst_n` is high.
- R2: Lane k takes bus bits [9k+8:9k]. Bit 9k+8 is the lane's parity bit and bits [9k+7:9k] are its data bits. The default build has lanes 0 to 3.
- R3: With `odd_sel`=1, a lane is good when its nine bits contain an odd number of ones. With `odd_sel`=0, a lane is good when the count is even.
- R4: At each rising edge with `rst_n` high, `perr_n` takes 0 if any lane of `din` is bad and 1 if all lanes are good. The new value is visible after that edge and is recomputed on every cycle.
- R5: Checking is passive. `din` has no effect on `dout`.
- R6: With `gen_en`=1, each lane of `dout` carries the data bits of `dout_raw` unchanged. Its parity bit is replaced by the value that makes the lane good under R3. This happens in the same cycle, with no register in the path.
- R7: With `gen_en`=0, `dout` equals `dout_raw` bit for bit, including bad parity bits.
- R8: A single flipped bit in any one lane, data or parity, drives `perr_n` low, whatever the state of the other lanes.
- R9: Changing `odd_sel` alone flips the verdict on every lane and flips every generated parity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| odd_sel | input | 1 | Parity sense: 1 = odd, 0 = even |
| gen_en | input | 1 | Enables parity rewrite on the outgoing word |
| din | input | 36 | Incoming word under check |
| dout_raw | input | 36 | Outgoing word before generation |
| dout | output | 36 | Outgoing word after optional generation |
| perr_n | output | 1 | Registered parity error flag, active low |

## Verification
The generated output `dout` is combinational, so the bench checks it one nanosecond after driving the inputs at a falling edge, with no clock edge in between. `perr_n` comes one register later. The bench keeps the same inputs through the next rising edge and reads the flag one nanosecond after that edge, against a verdict computed from the word it drove. The reset check reads the flag during reset while a bad word is driven.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

   // Default lane geometry
   localparam int LANES_DEF     = 4;
   localparam int LANE_DATA_DEF = 8;

   // Parity sense as carried on the select input
   typedef enum logic {
      SENSE_EVEN = 1'b0,
      SENSE_ODD  = 1'b1
   } par_sense_e;

endpackage

// File: rtl/ppg_lane_code.sv
module ppg_lane_code #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] data,
   input  logic          odd_sel,
   output logic          code_bit
);
   import ppg_pkg::*;

   if (DW < 1) begin : g_bad_dw
      $error("ppg_lane_code: DW must be at least 1");
   end

   par_sense_e sense;
   logic       data_xor;

   assign sense = par_sense_e'(odd_sel);

   always_comb begin
      data_xor = ^data;
      // the bit that brings the lane's ones count to the chosen sense
      code_bit = (sense == SENSE_ODD) ? ~data_xor : data_xor;
   end

endmodule

// File: rtl/ppg_check.sv
module ppg_check #(
   parameter int LANES     = 4,
   parameter int LANE_DATA = 8,
   localparam int LANE_W   = LANE_DATA + 1,
   localparam int BUS_W    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             odd_sel,
   input  logic [BUS_W-1:0] din,
   output logic             perr_n
);

   if (LANES < 1) begin : g_bad_lanes
      $error("ppg_check: LANES must be at least 1");
   end

   logic [LANES-1:0] lane_bad;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic expect_bit;
      logic got_bit;

      ppg_lane_code #(.DW(LANE_DATA)) u_code (
         .data    (din[k*LANE_W +: LANE_DATA]),
         .odd_sel (odd_sel),
         .code_bit(expect_bit)
      );

      assign got_bit     = din[k*LANE_W + LANE_DATA];
      assign lane_bad[k] = got_bit ^ expect_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) perr_n <= 1'b1;
      else        perr_n <= ~(|lane_bad);
   end

   // checker state: armed one cycle after reset release
   logic chk_armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_armed <= 1'b0;
      else        chk_armed <= 1'b1;
   end

   logic [LANES-1:0] lane_odd_cnt;
   for (genvar k = 0; k < LANES; k++) begin : g_cnt
      assign lane_odd_cnt[k] = ($countones(din[k*LANE_W +: LANE_W]) % 2) == 1;
   end

   // R1
   reset_flag_chk: assert property (@(posedge clk) !rst_n |=> perr_n);

   // R4
   err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed |-> (perr_n == ($past(lane_odd_cnt) == {LANES{$past(odd_sel)}})));

endmodule

// File: rtl/ppg_gen.sv
module ppg_gen #(
   parameter int LANES     = 4,
   parameter int LANE_DATA = 8,
   localparam int LANE_W   = LANE_DATA + 1,
   localparam int BUS_W    = LANES * LANE_W
) (
   input  logic             odd_sel,
   input  logic             gen_en,
   input  logic [BUS_W-1:0] raw,
   output logic [BUS_W-1:0] cooked
);

   if (LANES < 1) begin : g_bad_lanes
      $error("ppg_gen: LANES must be at least 1");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic fresh_bit;

      ppg_lane_code #(.DW(LANE_DATA)) u_code (
         .data    (raw[k*LANE_W +: LANE_DATA]),
         .odd_sel (odd_sel),
         .code_bit(fresh_bit)
      );

      assign cooked[k*LANE_W +: LANE_DATA] = raw[k*LANE_W +: LANE_DATA];
      assign cooked[k*LANE_W + LANE_DATA]  =
         gen_en ? fresh_bit : raw[k*LANE_W + LANE_DATA];
   end

endmodule

// File: rtl/ppg_port.sv
module ppg_port #(
   parameter int LANES     = ppg_pkg::LANES_DEF,
   parameter int LANE_DATA = ppg_pkg::LANE_DATA_DEF,
   localparam int LANE_W   = LANE_DATA + 1,
   localparam int BUS_W    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             odd_sel,
   input  logic             gen_en,
   input  logic [BUS_W-1:0] din,
   input  logic [BUS_W-1:0] dout_raw,
   output logic [BUS_W-1:0] dout,
   output logic             perr_n
);

   ppg_check #(.LANES(LANES), .LANE_DATA(LANE_DATA)) u_check (
      .clk    (clk),
      .rst_n  (rst_n),
      .odd_sel(odd_sel),
      .din    (din),
      .perr_n (perr_n)
   );

   ppg_gen #(.LANES(LANES), .LANE_DATA(LANE_DATA)) u_gen (
      .odd_sel(odd_sel),
      .gen_en (gen_en),
      .raw    (dout_raw),
      .cooked (dout)
   );

   // R7
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |-> (dout == dout_raw));

   for (genvar k = 0; k < LANES; k++) begin : g_gen_chk
      // R6
      gen_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
         gen_en |-> ((($countones(dout[k*LANE_W +: LANE_W]) % 2) == 1) == odd_sel));
      // R6
      gen_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dout[k*LANE_W +: LANE_DATA] == dout_raw[k*LANE_W +: LANE_DATA]);
   end

endmodule

// File: tb/ppg_port_bench.sv
`timescale 1ns/1ps
module ppg_port_bench;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int BW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          odd_sel = 1'b0;
   logic          gen_en = 1'b0;
   logic [BW-1:0] din = '0;
   logic [BW-1:0] dout_raw = '0;
   logic [BW-1:0] dout;
   logic          perr_n;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   ppg_port u_ppg_port (
      .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .gen_en(gen_en),
      .din(din), .dout_raw(dout_raw), .dout(dout), .perr_n(perr_n)
   );

   function automatic bit lane_good(input logic [LW-1:0] l, input bit odd);
      int c = 0;
      for (int i = 0; i < LW; i++) c += l[i];
      return ((c % 2) == 1) == odd;
   endfunction

   function automatic bit exp_flag(input logic [BW-1:0] w, input bit odd);
      bit ok = 1'b1;
      for (int k = 0; k < NL; k++) if (!lane_good(w[k*LW +: LW], odd)) ok = 1'b0;
      return ok;
   endfunction

   function automatic logic [BW-1:0] exp_out(input logic [BW-1:0] w, input bit odd, input bit gen);
      logic [BW-1:0] r = w;
      if (gen)
         for (int k = 0; k < NL; k++) begin
            logic [LW-1:0] l = w[k*LW +: LW];
            l[LW-1] = 1'b0;
            if (!lane_good(l, odd)) l[LW-1] = 1'b1;
            r[k*LW +: LW] = l;
         end
      return r;
   endfunction

   function automatic logic [BW-1:0] good_word(input bit odd);
      logic [BW-1:0] w;
      for (int k = 0; k < NL; k++) begin
         logic [LW-1:0] l = {1'b0, 8'($urandom)};
         if (!lane_good(l, odd)) l[LW-1] = 1'b1;
         w[k*LW +: LW] = l;
      end
      return w;
   endfunction

   task automatic check_bit(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_word(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // drive at falling edge, check dout at once, flag after next rising edge
   task automatic apply(input string req, input logic [BW-1:0] d, input logic [BW-1:0] r,
                        input bit odd, input bit gen);
      @(negedge clk);
      din = d; dout_raw = r; odd_sel = odd; gen_en = gen;
      #1;
      check_word({req, " dout"}, dout, exp_out(r, odd, gen));
      @(posedge clk);
      #1;
      check_bit({req, " perr_n"}, perr_n, exp_flag(d, odd));
   endtask

   initial begin : watchdog
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      logic [BW-1:0] w;
      logic [BW-1:0] raw;
      void'($urandom(32'h5eed_0042));

      // R1: bad word during reset, flag must hold high
      din = {BW{1'b1}} ^ 36'h1;
      odd_sel = 1'b1;
      repeat (3) @(posedge clk);
      #1 check_bit("R1 reset", perr_n, 1'b1);
      @(negedge clk); rst_n = 1'b1;

      // R3: all zeros: good when even, every lane bad when odd
      apply("R3 zeros even", '0, '0, 1'b0, 1'b1);
      apply("R3 zeros odd",  '0, '0, 1'b1, 1'b1);

      // R2 R8: single-bit flip in each lane, both data and parity positions
      for (int k = 0; k < NL; k++) begin
         w = good_word(1'b1);
         w[k*LW + LW - 1] = ~w[k*LW + LW - 1];
         apply("R8 parity flip", w, w, 1'b1, 1'b0);
         w = good_word(1'b0);
         w[k*LW + 3] = ~w[k*LW + 3];
         apply("R2 data flip", w, w, 1'b0, 1'b0);
      end

      // R9: same word, sense flipped
      w = good_word(1'b1);
      apply("R9 sense odd", w, w, 1'b1, 1'b1);
      apply("R9 sense even", w, w, 1'b0, 1'b1);

      // R7: bad parity passes through untouched
      raw = good_word(1'b0) ^ {NL{1'b1, 8'h00}};
      apply("R7 passthru", good_word(1'b0), raw, 1'b0, 1'b0);

      // R5: din changes, dout_raw fixed, dout must not move
      raw = {$urandom, 4'($urandom)};
      apply("R5 din a", '0, raw, 1'b1, 1'b1);
      apply("R5 din b", {BW{1'b1}}, raw, 1'b1, 1'b1);

      // R4 R6: random traffic, some corrupted words
      for (int n = 0; n < 400; n++) begin
         bit odd = 1'($urandom);
         w = good_word(odd);
         if ($urandom_range(0, 2) == 0) w[$urandom_range(0, BW-1)] ^= 1'b1;
         raw = {$urandom, 4'($urandom)};
         apply("R4 R6 random", w, raw, odd, 1'($urandom));
      end

      // R1: reset mid-run forces flag high
      @(negedge clk); din = '0; odd_sel = 1'b1; rst_n = 1'b0;
      #1 check_bit("R1 async reset", perr_n, 1'b1);
      @(negedge clk); rst_n = 1'b1;

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule